// File: doc/BRIEF.md
# GIOP Reply Marshaller for Register Reads

This block turns the result of a decoded read-type request into a complete outgoing GIOP Reply message, serialised one byte at a time. A request carries a request identifier, a byte-order flag, an operation index and one 64-bit slot for each read-back register word. The operation index picks a row of a parameter table that is fixed at elaboration. Each row gives how many words the operation returns and the width type of each word: octet, unsigned short, unsigned long or unsigned long long.

When a request is accepted, the message length follows from the table row alone. The 12-byte fixed header, with its size field, is therefore emitted first. The reply header comes next, then the body. No part of the message is buffered. The body carries the words in table order, with zero padding ahead of any word that would otherwise sit off its natural alignment. The output is a byte stream with a valid/ready handshake and first-byte and last-byte markers.

Top module: `grm_reply_marshal`

## Requirements
- R1: Message bytes 0..7 are 0x47 0x49 0x4F 0x50 (the magic), 0x01 0x00 (version 1.0), a flags byte whose bit 0 equals the request's byte-order flag and whose other bits are zero, and 0x01 (Reply).
- R2: Bytes 8..11 hold the total message length minus 12 as a 32-bit unsigned value, in the request's byte order.
- R3: Bytes 12..23 are a zero service-context count (4 bytes), the echoed request id (4 bytes, request byte order) and a zero reply status (4 bytes).
- R4: Starting at byte 24, one value is sent per table entry, in table order. Type code 0 takes 1 byte, code 1 takes 2, code 2 takes 4 and code 3 takes 8. Each value is the low bytes of its 64-bit input slot; slot p sits at bits [64p+63:64p] of the word input.
- R5: Before each value, zero bytes are inserted until its offset from the first message byte is a multiple of its byte width.
- R6: Multi-byte fields are sent most significant byte first when the byte-order flag is 0, and least significant byte first when it is 1.
- R7: While valid is high and ready is low, the output byte and both markers stay unchanged and valid stays high.
- R8: The first-byte marker is high only on byte 0. The last-byte marker is high only on the final byte of the message, and valid falls right after that byte is accepted.
- R9: The request input is ready only when no message is being sent. A request held during a message is taken only after the final byte, and each request yields exactly one message.
- R10: After reset, valid is low and the request input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read result is present |
| req_ready | output | 1 | Marshaller is idle and takes the read result |
| req_id | input | 32 | Request id to echo |
| req_little | input | 1 | Byte-order flag: 0 big-endian, 1 little-endian |
| req_op | input | OP_W (2) | Operation index selecting a parameter-table row |
| req_words | input | NPARAM*64 (256) | Register words, slot p at bits [64p+63:64p] |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Message byte |
| out_sop | output | 1 | First byte of a message |
| out_eop | output | 1 | Last byte of a message |

## Verification
The acceptance of a message's final byte can fall in the same cycle as a new request that has been waiting at the input. In that cycle the block must finish one message and arm the next without losing or repeating either. The bench provokes this by presenting requests back to back while the sink applies random and heavy backpressure. A behavioural byte-queue model, built from the requirements, is compared with the ports on every clock, so a missed, doubled or early-accepted request shows up as a ready, valid or data mismatch.

// File: rtl/grm_pkg.sv
package grm_pkg;

    localparam int unsigned HDR_BYTES  = 12;
    localparam int unsigned BODY_START = 24;

    typedef enum logic [1:0] {
        T_OCTET = 2'd0,
        T_SHORT = 2'd1,
        T_LONG  = 2'd2,
        T_LLONG = 2'd3
    } ptype_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } st_e;

endpackage

// File: rtl/grm_layout.sv
// Computes the aligned start offset of every parameter and the message end
// offset for one table row; offsets count from the first message byte.
module grm_layout #(
    parameter int NPARAM = 4,
    parameter int NUM_W  = 3,
    parameter int POS_W  = 7
) (
    input  logic [NPARAM*2-1:0]     types,
    input  logic [NUM_W-1:0]        count,
    output logic [NPARAM*POS_W-1:0] starts,
    output logic [POS_W-1:0]        msg_end
);
    import grm_pkg::*;

    logic [POS_W-1:0] off;
    logic [POS_W-1:0] sz;
    logic [POS_W-1:0] al;

    always_comb begin
        off    = POS_W'(BODY_START);
        starts = '0;
        sz     = '0;
        al     = '0;
        for (int p = 0; p < NPARAM; p++) begin
            sz = POS_W'(1) << types[p*2 +: 2];
            al = (off + sz - POS_W'(1)) & ~(sz - POS_W'(1));
            starts[p*POS_W +: POS_W] = al;
            if (p < int'(count)) begin
                off = al + sz;
            end
        end
        msg_end = off;
    end

endmodule

// File: rtl/grm_byte_pick.sv
// Selects byte idx of a field of 2**lg bytes in the requested byte order.
module grm_byte_pick (
    input  logic [63:0] value,
    input  logic [1:0]  lg,
    input  logic [2:0]  idx,
    input  logic        little,
    output logic [7:0]  byte_o
);
    logic [2:0] top;
    logic [2:0] sel;

    always_comb begin
        top    = 3'((4'd1 << lg) - 4'd1);
        sel    = little ? idx : (top - idx);
        byte_o = value[{sel, 3'b000} +: 8];
    end

endmodule

// File: rtl/grm_reply_marshal.sv
module grm_reply_marshal #(
    parameter int NPARAM   = 4,
    parameter int OP_COUNT = 4,
    parameter int NUM_W    = $clog2(NPARAM + 1),
    parameter int OP_W     = (OP_COUNT > 1) ? $clog2(OP_COUNT) : 1,
    // row r, entry p: type code at bits [r*NPARAM*2 + p*2 +: 2]
    parameter logic [OP_COUNT*NPARAM*2-1:0] OP_TYPES = 32'h0031_0802,
    // row r: number of returned words at bits [r*NUM_W +: NUM_W]
    parameter logic [OP_COUNT*NUM_W-1:0]    OP_NUM   = 12'h0D1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [31:0]           req_id,
    input  logic                  req_little,
    input  logic [OP_W-1:0]       req_op,
    input  logic [NPARAM*64-1:0]  req_words,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [7:0]            out_data,
    output logic                  out_sop,
    output logic                  out_eop
);
    import grm_pkg::*;

    localparam int MAX_END = BODY_START + NPARAM * 16;
    localparam int POS_W   = $clog2(MAX_END + 1);
    localparam int PIDX_W  = $clog2(NPARAM + 1);

    typedef struct packed {
        st_e                 st;
        logic [POS_W-1:0]    pos;
        logic [PIDX_W-1:0]   pidx;
        logic                little;
        logic [31:0]         id;
        logic [OP_W-1:0]     op;
        logic [NPARAM*64-1:0] words;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NPARAM*2-1:0]     row_types;
    logic [NUM_W-1:0]        row_count;
    logic [NPARAM*POS_W-1:0] starts;
    logic [POS_W-1:0]        msg_end;
    logic [31:0]             size32;
    logic [POS_W-1:0]        cur_start;
    logic [1:0]              cur_t;
    logic [63:0]             cur_word;
    logic [2:0]              body_off;
    logic                    in_pad;
    logic                    last_byte;
    logic [63:0]             hdr_val;
    logic [7:0]              hdr_byte;
    logic [7:0]              body_byte;
    logic [7:0]              data_c;

    assign row_types = OP_TYPES[ctl_q.op * (NPARAM*2) +: NPARAM*2];
    assign row_count = OP_NUM[ctl_q.op * NUM_W +: NUM_W];

    grm_layout #(
        .NPARAM (NPARAM),
        .NUM_W  (NUM_W),
        .POS_W  (POS_W)
    ) u_layout (
        .types   (row_types),
        .count   (row_count),
        .starts  (starts),
        .msg_end (msg_end)
    );

    always_comb begin
        size32    = 32'(msg_end) - 32'(HDR_BYTES);
        cur_start = '0;
        cur_t     = '0;
        cur_word  = '0;
        for (int p = 0; p < NPARAM; p++) begin
            if (ctl_q.pidx == PIDX_W'(p)) begin
                cur_start = starts[p*POS_W +: POS_W];
                cur_t     = row_types[p*2 +: 2];
                cur_word  = ctl_q.words[p*64 +: 64];
            end
        end
        in_pad    = ctl_q.pos < cur_start;
        body_off  = 3'(ctl_q.pos - cur_start);
        last_byte = ctl_q.pos == (msg_end - POS_W'(1));
        hdr_val   = (ctl_q.pos < POS_W'(HDR_BYTES)) ? {32'd0, size32}
                                                     : {32'd0, ctl_q.id};
    end

    // size field (bytes 8..11) and request id (bytes 16..19) share one picker
    grm_byte_pick u_hdr_pick (
        .value  (hdr_val),
        .lg     (2'd2),
        .idx    ({1'b0, ctl_q.pos[1:0]}),
        .little (ctl_q.little),
        .byte_o (hdr_byte)
    );

    grm_byte_pick u_body_pick (
        .value  (cur_word),
        .lg     (cur_t),
        .idx    (body_off),
        .little (ctl_q.little),
        .byte_o (body_byte)
    );

    always_comb begin
        data_c = 8'h00;
        if (ctl_q.pos < POS_W'(HDR_BYTES)) begin
            case (ctl_q.pos[3:0])
                4'd0:    data_c = 8'h47;
                4'd1:    data_c = 8'h49;
                4'd2:    data_c = 8'h4F;
                4'd3:    data_c = 8'h50;
                4'd4:    data_c = 8'h01;
                4'd5:    data_c = 8'h00;
                4'd6:    data_c = {7'd0, ctl_q.little};
                4'd7:    data_c = 8'h01;
                default: data_c = hdr_byte;
            endcase
        end else if (ctl_q.pos < POS_W'(BODY_START)) begin
            if (ctl_q.pos >= POS_W'(16) && ctl_q.pos < POS_W'(20)) begin
                data_c = hdr_byte;
            end
        end else if (!in_pad) begin
            data_c = body_byte;
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st     = ST_SEND;
                    ctl_d.pos    = '0;
                    ctl_d.pidx   = '0;
                    ctl_d.little = req_little;
                    ctl_d.id     = req_id;
                    ctl_d.op     = req_op;
                    ctl_d.words  = req_words;
                end
            end
            default: begin
                if (out_ready) begin
                    if (last_byte) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.pos = ctl_q.pos + POS_W'(1);
                        if (ctl_q.pos >= POS_W'(BODY_START) && !in_pad &&
                            body_off == 3'((4'd1 << cur_t) - 4'd1)) begin
                            ctl_d.pidx = ctl_q.pidx + PIDX_W'(1);
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = ctl_q.st == ST_IDLE;
    assign out_valid = ctl_q.st == ST_SEND;
    assign out_data  = out_valid ? data_c : 8'h00;
    assign out_sop   = out_valid && ctl_q.pos == '0;
    assign out_eop   = out_valid && last_byte;

endmodule

// File: rtl/grm_checks.sv
module grm_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_sop,
    input logic       out_eop
);
    // R7: a stalled byte is held
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    // R9: no request taken while a message is in flight
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    // R8: a message begins with the first-byte marker
    p_sop_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sop);

    // R8: valid drops after the last byte is taken
    p_eop_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    // R1: the first byte is the magic's first letter
    p_magic_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> out_data == 8'h47);

    // R8: markers only with valid
    p_mark_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);
endmodule

bind grm_reply_marshal grm_checks u_grm_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/grm_reply_marshal_bench.sv
module grm_reply_marshal_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_id = '0;
    logic         req_little = 1'b0;
    logic [1:0]   req_op = '0;
    logic [255:0] req_words = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [7:0]   out_data;
    logic         out_sop;
    logic         out_eop;

    int n_checks = 0;
    int n_bad = 0;
    int cycles = 0;
    int ready_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grm_reply_marshal u_grm_reply_marshal (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_little(req_little), .req_op(req_op),
        .req_words(req_words), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    typedef struct {
        logic [7:0] d;
        bit         s;
        bit         e;
        string      tag;
    } ent_t;

    ent_t exp_q[$];
    bit   busy = 0;
    bit   prev_stall = 0;
    logic [7:0] prev_data = '0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // operation table as the requirements state it
    function automatic int nwords(int op);
        case (op)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int wbytes(int op, int p);
        if (op == 0) return 4;
        if (op == 1) return (p == 0) ? 1 : 4;
        if (op == 2) return (p == 0) ? 2 : ((p == 1) ? 1 : 8);
        return 1;
    endfunction

    task automatic add(logic [7:0] d, string tag);
        ent_t e;
        e.d = d; e.s = 0; e.e = 0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic build(int op, logic [31:0] id, bit le, logic [255:0] w);
        int first = exp_q.size();
        int pos = 24;
        int endp;
        int sz;
        for (int p = 0; p < nwords(op); p++) begin
            int a = wbytes(op, p);
            pos = ((pos + a - 1) / a) * a + a;
        end
        endp = pos;
        sz = endp - 12;
        add(8'h47, "R1"); add(8'h49, "R1"); add(8'h4F, "R1"); add(8'h50, "R1");
        add(8'h01, "R1"); add(8'h00, "R1"); add({7'd0, le}, "R1"); add(8'h01, "R1");
        for (int k = 0; k < 4; k++) add(8'(sz >> (8 * (le ? k : 3 - k))), "R2");
        for (int k = 0; k < 4; k++) add(8'h00, "R3");
        for (int k = 0; k < 4; k++) add(id[8 * (le ? k : 3 - k) +: 8], "R3");
        for (int k = 0; k < 4; k++) add(8'h00, "R3");
        pos = 24;
        for (int p = 0; p < nwords(op); p++) begin
            int a = wbytes(op, p);
            while (pos % a != 0) begin
                add(8'h00, "R5");
                pos++;
            end
            for (int k = 0; k < a; k++) begin
                int sel = le ? k : a - 1 - k;
                add(w[p * 64 + sel * 8 +: 8], (a > 1) ? "R6" : "R4");
                pos++;
            end
        end
        exp_q[first].s = 1;
        exp_q[exp_q.size() - 1].e = 1;
    endtask

    // reference model, compared on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            bit acc;
            check(req_ready == !busy, "R9 ready", 32'(req_ready), 32'(!busy));
            check(out_valid == busy, "R8 valid", 32'(out_valid), 32'(busy));
            if (busy && out_valid) begin
                check(out_data == exp_q[0].d, exp_q[0].tag, 32'(out_data), 32'(exp_q[0].d));
                check(out_sop == exp_q[0].s, "R8 sop", 32'(out_sop), 32'(exp_q[0].s));
                check(out_eop == exp_q[0].e, "R8 eop", 32'(out_eop), 32'(exp_q[0].e));
                if (prev_stall)
                    check(out_data == prev_data, "R7 hold", 32'(out_data), 32'(prev_data));
            end
            prev_stall = busy && !out_ready;
            prev_data  = out_data;
            acc = req_valid && !busy;
            if (busy && out_ready) begin
                void'(exp_q.pop_front());
                if (exp_q.size() == 0) busy = 0;
            end
            if (acc) begin
                build(int'(req_op), req_id, req_little, req_words);
                busy = 1;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'($urandom % 2);
            default: out_ready = (($urandom % 6) == 0);
        endcase
    end

    task automatic send_req(int op, logic [31:0] id, bit le);
        req_op     = 2'(op);
        req_id     = id;
        req_little = le;
        req_words  = {$urandom, $urandom, $urandom, $urandom,
                      $urandom, $urandom, $urandom, $urandom};
        req_valid  = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R10 valid after reset", 32'(out_valid), 0);
        check(req_ready, "R10 ready after reset", 32'(req_ready), 1);

        ready_mode = 0;
        send_req(0, 32'h1122_3344, 0); wait_idle();   // R1 R2 R3 R6 big-endian
        send_req(0, 32'hA5A5_0F0F, 1); wait_idle();   // R6 little-endian
        ready_mode = 1;
        send_req(1, 32'h0000_0007, 0); wait_idle();   // R4 R5 octet then padded long
        send_req(2, 32'hDEAD_BEEF, 1); wait_idle();   // R5 padding ahead of 8-byte value
        ready_mode = 2;
        send_req(2, 32'h0BAD_F00D, 0); wait_idle();   // R7 long stalls
        ready_mode = 0;
        send_req(3, 32'h0000_0001, 1); wait_idle();   // R2 empty body, size 12
        ready_mode = 1;
        for (int i = 0; i < 6; i++) send_req(i % 4, 32'(i * 77 + 5), bit'(i % 2)); // R9 back to back
        wait_idle();
        ready_mode = 2;
        for (int i = 0; i < 4; i++) send_req(2 - (i % 3), 32'(i + 1000), bit'(i / 2));
        wait_idle();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                $display("test done: total=%0d bad=%0d", n_checks, n_bad);
                $finish;
            end
        end
    end

endmodule